// File: doc/BRIEF.md
# Supervisor Domain Protection Control Register

This block is a machine-level control register for a 64-bit hart. It holds three things: the page number of the root of a physical-memory permission table, a supervisor domain identifier (SDID), and a selector that picks the protection scheme. It receives CSR read and write requests, each tagged with the privilege level of the requester. It answers with read data, an illegal-instruction flag and a fault flag. It also drives the stored scheme, SDID and root page number to a downstream permission checker. An `active` indication tells that checker whether protection applies at the current effective privilege.

Nothing is stored raw. Each write is legalized field by field:

- A scheme value that the build does not support leaves the previous scheme in place.
- Only the implemented low SDID bits are kept, so software can discover the SDID width by writing all ones and reading the value back.
- The two lowest page-number bits are forced to zero in the page-based schemes.
- The reserved field reads as zero.
- A write that would leave the register in Bare mode with a nonzero SDID or page number raises a fault and is dropped.

Top module: `sd_prot_csr`

## Requirements
- R1: After reset the register reads as all zeros, which is Bare mode (scheme code 0), and the downstream outputs are all zero.
- R2: A request with privilege other than machine (privilege encoding 0 user, 1 supervisor, 2 treated as non-machine, 3 machine) asserts `illegal_o` in the same cycle. It returns zero read data and leaves the stored state unchanged.
- R3: Field positions are PPN in bits 43:0, a reserved field in bits 53:44, SDID in bits 59:54 and scheme in bits 63:60. `rd_data_o` shows the current value during a legal request, and a legal write takes effect on the next clock edge.
- R4: The scheme codes are 0 Bare, 1 page-based 46-bit, 2 page-based 56-bit, and 3 to 15 reserved. Writing a code that the build supports installs it.
- R5: A write whose scheme code is reserved or not supported keeps the previous scheme. The SDID and PPN fields of the same write are still legalized and stored.
- R6: Only SDID bits below `SDID_LEN` are stored. Higher SDID bits always read as zero.
- R7: While the scheme is page-based (code 1 or 2), PPN bits 1:0 read as zero whatever was written.
- R8: A write whose legalized result would be Bare with a nonzero SDID or nonzero PPN asserts `fault_o` in that cycle, and the register keeps its old value.
- R9: The reserved field, bits 53:44, always reads as zero.
- R10: `active_o` is high exactly when `eff_priv_i` is not machine (3).
- R11: `mode_o`, `sdid_o` and `ppn_o` always equal the stored register fields, as seen through a machine-mode read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | CSR access to this register this cycle |
| req_write_i | input | 1 | Access is a write |
| req_priv_i | input | 2 | Privilege of the requester |
| req_wdata_i | input | 64 | Write data |
| eff_priv_i | input | 2 | Effective privilege for protection |
| rd_data_o | output | 64 | Read data, zero unless a legal request |
| illegal_o | output | 1 | Illegal-instruction indication |
| fault_o | output | 1 | Bare-mode nonzero-field fault |
| mode_o | output | 4 | Stored scheme to the checker |
| sdid_o | output | 6 | Stored SDID to the checker |
| ppn_o | output | 44 | Stored root page number to the checker |
| active_o | output | 1 | Protection applies at the effective privilege |

## Verification
The bench builds the block with a 4-bit SDID and with the 46-bit scheme supported but not the 56-bit one. That configuration gives unsupported-but-defined codes something to fall back from.

The bench covers these corner cases:
- A write of code 2 or of a reserved code must keep the old scheme but still take the new SDID and PPN. A design that discarded the whole write, or stored the raw code, would read back the wrong fields.
- From Bare, an unsupported code with a nonzero PPN must fault, because the scheme stays Bare. A design that checked the raw code would miss this.
- Writing Bare with only SDID bit 5 set must not fault, since that bit is not implemented. A design that checked the SDID before masking would fault wrongly.
- Requests from user and supervisor level must neither read nor change anything.
- The low PPN bits must be cleared in page-based mode.
- The reserved bits must never appear in the read data.

// File: rtl/sd_prot_pkg.sv
// Package: shared field widths, scheme codes and the support test for the
// supervisor domain protection register. Assumes a 64-bit register layout.
package sd_prot_pkg;

    localparam int REG_W  = 64;
    localparam int PPN_W  = 44;
    localparam int RSV_W  = 10;
    localparam int SDID_W = 6;
    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_BARE = 4'd0;
    localparam logic [MODE_W-1:0] MODE_P46  = 4'd1;
    localparam logic [MODE_W-1:0] MODE_P56  = 4'd2;

    localparam logic [1:0] PRIV_MACHINE = 2'd3;

    // Returns true when a scheme code is supported by this build.
    function automatic logic mode_supported(input logic [MODE_W-1:0] m,
                                            input bit has46,
                                            input bit has56);
        logic ok;
        ok = 1'b0;
        if (m == MODE_BARE) ok = 1'b1;
        if (m == MODE_P46 && has46) ok = 1'b1;
        if (m == MODE_P56 && has56) ok = 1'b1;
        return ok;
    endfunction

endpackage

// File: rtl/sd_prot_access.sv
// Module: privilege gate. Decides whether a request is illegal and whether
// a write commits. Assumes privilege code 3 is machine and that every other
// code is a lower level.
module sd_prot_access
    import sd_prot_pkg::*;
(
    input  logic       req_valid_i,
    input  logic       req_write_i,
    input  logic [1:0] req_priv_i,
    input  logic       fault_i,
    output logic       illegal_o,
    output logic       read_ok_o,
    output logic       commit_o,
    output logic       fault_o
);

    logic is_machine;

    // Classify the request and gate the commit and fault outputs.
    always_comb begin
        is_machine = (req_priv_i == PRIV_MACHINE);
        illegal_o  = req_valid_i && !is_machine;
        read_ok_o  = req_valid_i && is_machine;
        fault_o    = req_valid_i && is_machine && req_write_i && fault_i;
        commit_o   = req_valid_i && is_machine && req_write_i && !fault_i;
    end

endmodule

// File: rtl/sd_prot_legalize.sv
// Module: write legalizer. Turns raw write data into legal field values and
// flags a Bare result that carries a nonzero SDID or PPN. The fault test is
// made on the legalized fields.
module sd_prot_legalize
    import sd_prot_pkg::*;
#(
    parameter int SDID_LEN = 4,
    parameter bit HAS_P46  = 1'b1,
    parameter bit HAS_P56  = 1'b0
) (
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [MODE_W-1:0] cur_mode_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [SDID_W-1:0] sdid_o,
    output logic [PPN_W-1:0]  ppn_o,
    output logic              fault_o
);

    localparam logic [SDID_W-1:0] SDID_MASK =
        SDID_W'((64'd1 << SDID_LEN) - 64'd1);
    localparam int MODE_LSB = REG_W - MODE_W;
    localparam int SDID_LSB = MODE_LSB - SDID_W;

    logic [MODE_W-1:0] req_mode;

    // Pick the new scheme, mask the SDID, clear the low PPN bits in paged schemes.
    always_comb begin
        req_mode = wdata_i[MODE_LSB +: MODE_W];
        mode_o   = mode_supported(req_mode, HAS_P46, HAS_P56) ? req_mode : cur_mode_i;
        sdid_o   = wdata_i[SDID_LSB +: SDID_W] & SDID_MASK;
        ppn_o    = wdata_i[PPN_W-1:0];
        if (mode_o != MODE_BARE) ppn_o[1:0] = 2'b00;
        fault_o  = (mode_o == MODE_BARE) && ((sdid_o != '0) || (ppn_o != '0));
    end

endmodule

// File: rtl/sd_prot_regs.sv
// Module: field storage. Holds the scheme, the implemented SDID bits and the
// PPN. Resets to zero. Unimplemented SDID bits are not stored at all.
module sd_prot_regs
    import sd_prot_pkg::*;
#(
    parameter int SDID_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [MODE_W-1:0] mode_d,
    input  logic [SDID_W-1:0] sdid_d,
    input  logic [PPN_W-1:0]  ppn_d,
    output logic [MODE_W-1:0] mode_q,
    output logic [SDID_W-1:0] sdid_q,
    output logic [PPN_W-1:0]  ppn_q
);

    // Store the scheme and PPN on a committed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_BARE;
            ppn_q  <= '0;
        end else if (we_i) begin
            mode_q <= mode_d;
            ppn_q  <= ppn_d;
        end
    end

    generate
        if (SDID_LEN > 0) begin : g_sdid
            logic [SDID_LEN-1:0] bits_q;
            // Store only the implemented SDID bits.
            always_ff @(posedge clk) begin
                if (!rst_n)    bits_q <= '0;
                else if (we_i) bits_q <= sdid_d[SDID_LEN-1:0];
            end
            if (SDID_LEN < SDID_W) begin : g_pad
                assign sdid_q = {{(SDID_W-SDID_LEN){1'b0}}, bits_q};
            end else begin : g_full
                assign sdid_q = bits_q;
            end
        end else begin : g_nosdid
            assign sdid_q = '0;
        end
    endgenerate

endmodule

// File: rtl/sd_prot_csr.sv
// Module: top of the supervisor domain protection register. Joins the
// privilege gate, the legalizer and the storage. Drives read data and the
// checker-facing fields. Read data shows the value held before the
// current cycle's write.
module sd_prot_csr
    import sd_prot_pkg::*;
#(
    parameter int SDID_LEN = 4,
    parameter bit HAS_P46  = 1'b1,
    parameter bit HAS_P56  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [1:0]        req_priv_i,
    input  logic [REG_W-1:0]  req_wdata_i,
    input  logic [1:0]        eff_priv_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              illegal_o,
    output logic              fault_o,
    output logic [MODE_W-1:0] mode_o,
    output logic [SDID_W-1:0] sdid_o,
    output logic [PPN_W-1:0]  ppn_o,
    output logic              active_o
);

    logic [MODE_W-1:0] new_mode;
    logic [SDID_W-1:0] new_sdid;
    logic [PPN_W-1:0]  new_ppn;
    logic              leg_fault;
    logic              read_ok;
    logic              commit;

    sd_prot_legalize #(
        .SDID_LEN (SDID_LEN),
        .HAS_P46  (HAS_P46),
        .HAS_P56  (HAS_P56)
    ) u_leg (
        .wdata_i    (req_wdata_i),
        .cur_mode_i (mode_o),
        .mode_o     (new_mode),
        .sdid_o     (new_sdid),
        .ppn_o      (new_ppn),
        .fault_o    (leg_fault)
    );

    sd_prot_access u_acc (
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_priv_i  (req_priv_i),
        .fault_i     (leg_fault),
        .illegal_o   (illegal_o),
        .read_ok_o   (read_ok),
        .commit_o    (commit),
        .fault_o     (fault_o)
    );

    sd_prot_regs #(
        .SDID_LEN (SDID_LEN)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (commit),
        .mode_d (new_mode),
        .sdid_d (new_sdid),
        .ppn_d  (new_ppn),
        .mode_q (mode_o),
        .sdid_q (sdid_o),
        .ppn_q  (ppn_o)
    );

    // Assemble read data with the reserved field as zero, only for a legal request.
    always_comb begin
        rd_data_o = read_ok ? {mode_o, sdid_o, {RSV_W{1'b0}}, ppn_o} : '0;
    end

    // Protection applies below machine level.
    always_comb begin
        active_o = (eff_priv_i != PRIV_MACHINE);
    end

endmodule

// File: rtl/sd_prot_csr_chk.sv
// Module: property checker bound to sd_prot_csr. Watches the ports for
// illegal state and for state changes on requests that must not commit.
module sd_prot_csr_chk
    import sd_prot_pkg::*;
#(
    parameter int SDID_LEN = 4,
    parameter bit HAS_P46  = 1'b1,
    parameter bit HAS_P56  = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_write_i,
    input logic [1:0]        req_priv_i,
    input logic [REG_W-1:0]  rd_data_o,
    input logic              illegal_o,
    input logic              fault_o,
    input logic [1:0]        eff_priv_i,
    input logic [MODE_W-1:0] mode_o,
    input logic [SDID_W-1:0] sdid_o,
    input logic [PPN_W-1:0]  ppn_o,
    input logic              active_o
);

    localparam logic [SDID_W-1:0] HIGH_MASK =
        ~SDID_W'((64'd1 << SDID_LEN) - 64'd1);

    // R2
    illegal_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> ($stable(mode_o) && $stable(sdid_o) && $stable(ppn_o)));

    // R2
    illegal_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (rd_data_o == '0));

    // R4
    mode_supported_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_supported(mode_o, HAS_P46, HAS_P56));

    // R6
    sdid_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdid_o & HIGH_MASK) == '0);

    // R7
    ppn_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_BARE) |-> (ppn_o[1:0] == 2'b00));

    // R8
    bare_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_BARE) |-> (sdid_o == '0 && ppn_o == '0));

    // R8
    fault_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> ($stable(mode_o) && $stable(sdid_o) && $stable(ppn_o)));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[PPN_W +: RSV_W] == '0);

    // R10
    active_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_o == (eff_priv_i != PRIV_MACHINE));

endmodule

bind sd_prot_csr sd_prot_csr_chk #(
    .SDID_LEN (SDID_LEN),
    .HAS_P46  (HAS_P46),
    .HAS_P56  (HAS_P56)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_priv_i  (req_priv_i),
    .rd_data_o   (rd_data_o),
    .illegal_o   (illegal_o),
    .fault_o     (fault_o),
    .eff_priv_i  (eff_priv_i),
    .mode_o      (mode_o),
    .sdid_o      (sdid_o),
    .ppn_o       (ppn_o),
    .active_o    (active_o)
);

// File: tb/sd_prot_csr_tb.sv
// Directed bench for sd_prot_csr with a 4-bit SDID and only the 46-bit scheme.
module sd_prot_csr_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [1:0]  req_priv_i = 2'd3;
    logic [63:0] req_wdata_i = '0;
    logic [1:0]  eff_priv_i = 2'd3;
    logic [63:0] rd_data_o;
    logic        illegal_o;
    logic        fault_o;
    logic [3:0]  mode_o;
    logic [5:0]  sdid_o;
    logic [43:0] ppn_o;
    logic        active_o;

    int n_vec = 0;
    int n_bad = 0;

    sd_prot_csr #(.SDID_LEN(4), .HAS_P46(1'b1), .HAS_P56(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i),
        .req_write_i(req_write_i), .req_priv_i(req_priv_i),
        .req_wdata_i(req_wdata_i), .eff_priv_i(eff_priv_i),
        .rd_data_o(rd_data_o), .illegal_o(illegal_o), .fault_o(fault_o),
        .mode_o(mode_o), .sdid_o(sdid_o), .ppn_o(ppn_o), .active_o(active_o)
    );

    always #2 clk = ~clk;

    function automatic logic [63:0] pack(input logic [3:0] m, input logic [5:0] s,
                                         input logic [9:0] r, input logic [43:0] p);
        return {m, s, r, p};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access; samples flags and read data before the committing edge.
    task automatic access(input logic [1:0] priv, input logic wr, input logic [63:0] wd,
                          output logic [63:0] rd, output logic ill, output logic flt);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = wr; req_priv_i = priv; req_wdata_i = wd;
        #1;
        rd = rd_data_o; ill = illegal_o; flt = fault_o;
        @(negedge clk);
        req_valid_i = 1'b0; req_write_i = 1'b0; req_priv_i = 2'd3; req_wdata_i = '0;
    endtask

    task automatic read_back(input string req, input logic [63:0] exp);
        logic [63:0] rd; logic ill, flt;
        access(2'd3, 1'b0, '0, rd, ill, flt);
        check(req, rd, exp);
        check({req, " outputs"}, {mode_o, sdid_o, 10'd0, ppn_o}, exp); // R11
    endtask

    task automatic t_reset();
        read_back("R1 reset value", 64'd0);
        check("R1 mode_o after reset", {60'd0, mode_o}, 64'd0);
    endtask

    task automatic t_paged_write();
        logic [63:0] rd; logic ill, flt;
        access(2'd3, 1'b1, 64'h1FFF_FFFF_FFFF_FFFF, rd, ill, flt);
        check("R3 write no fault", {63'd0, flt}, 64'd0);
        // R4 R6 R7 R9: mode 1, SDID 0xF, PPN low bits clear, reserved zero
        read_back("R4 R6 R7 R9 paged write", pack(4'd1, 6'h0F, 10'd0, 44'hFFF_FFFF_FFFC));
    endtask

    task automatic t_unsupported_mode();
        logic [63:0] rd; logic ill, flt;
        access(2'd3, 1'b1, pack(4'd2, 6'h05, 10'h3FF, 44'h123457), rd, ill, flt);
        check("R3 read shows old value during write", rd, pack(4'd1, 6'h0F, 10'd0, 44'hFFF_FFFF_FFFC));
        read_back("R5 mode 2 unsupported keeps mode", pack(4'd1, 6'h05, 10'd0, 44'h123454));
        access(2'd3, 1'b1, pack(4'd9, 6'h3A, 10'd0, 44'h0ABC), rd, ill, flt);
        read_back("R5 reserved mode keeps mode", pack(4'd1, 6'h0A, 10'd0, 44'h0ABC));
    endtask

    task automatic t_illegal();
        logic [63:0] rd; logic ill, flt;
        for (int pv = 0; pv < 3; pv++) begin
            access(2'(pv), 1'b1, 64'd0, rd, ill, flt);
            check("R2 illegal flag", {63'd0, ill}, 64'd1);
            check("R2 illegal read data", rd, 64'd0);
        end
        read_back("R2 state unchanged", pack(4'd1, 6'h0A, 10'd0, 44'h0ABC));
    endtask

    task automatic t_bare_fault();
        logic [63:0] rd; logic ill, flt;
        access(2'd3, 1'b1, pack(4'd0, 6'h00, 10'd0, 44'h10), rd, ill, flt);
        check("R8 bare nonzero ppn faults", {63'd0, flt}, 64'd1);
        read_back("R8 faulted write dropped", pack(4'd1, 6'h0A, 10'd0, 44'h0ABC));
        access(2'd3, 1'b1, pack(4'd0, 6'h20, 10'h155, 44'd0), rd, ill, flt);
        check("R6 R8 unimplemented sdid bit no fault", {63'd0, flt}, 64'd0);
        read_back("R8 bare accepted", 64'd0);
        access(2'd3, 1'b1, pack(4'd2, 6'h00, 10'd0, 44'h4), rd, ill, flt);
        check("R5 R8 stays bare so faults", {63'd0, flt}, 64'd1);
        read_back("R5 R8 still bare", 64'd0);
    endtask

    task automatic t_active();
        for (int pv = 0; pv < 4; pv++) begin
            @(negedge clk);
            eff_priv_i = 2'(pv);
            #1;
            check("R10 active", {63'd0, active_o}, (pv != 3) ? 64'd1 : 64'd0);
        end
        eff_priv_i = 2'd3;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_paged_write();
        t_unsupported_mode();
        t_illegal();
        t_bare_fault();
        t_active();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule